// File: doc/BRIEF.md
# Masked-Write GPIO Port Bank

This block is a 32-pin general-purpose I/O port. A simple memory-mapped bus reaches its registers. The port holds an output-level register and a direction register, and it drives the pad output and output-enable vectors straight from them. It also offers a read-only view of the pad levels after synchronization, and a constant identification word.

Each 32-bit logical control register is stored as two 16-bit physical words. The low pin half sits at the register's base offset and the high pin half at base plus four. A write to one of these words uses its lower 16 bits as data and its upper 16 bits as a per-bit enable. Software can therefore set or clear any group of pins in one bus write, with no read-modify-write and no lock. The bus has one select line and one write line. Writes take effect on the next rising clock edge, and read data is a combinational function of the address and the stored state.

The reset input is asynchronous and active low. Its release is expected to be synchronous to `clk` already.

Top module: `gpio_hw_bank`

## Requirements
- R1: While reset is low and right after it, the output-level and direction registers are all zero. `pad_out` and `pad_oe` are therefore zero and every pin is an input.
- R2: A write to a masked word updates stored bit i (i = 0..15) to `bus_wdata[i]` only when `bus_wdata[i+16]` is 1. Every bit whose enable is 0 keeps its value.
- R3: The output-level register's pins 0..15 live in the word at offset 0x00 and pins 16..31 in the word at offset 0x04. A write to one of these words never changes the other half.
- R4: The direction register uses offset 0x08 for pins 0..15 and 0x0C for pins 16..31. `pad_oe[i]` equals its bit i, where 1 means output and 0 means input.
- R5: A read of offset 0x00, 0x04, 0x08 or 0x0C returns that word's 16 stored bits in `bus_rdata[15:0]` and zero in `bus_rdata[31:16]`. Placing the word at +4 above the word at +0 rebuilds the full logical register.
- R6: A read of offset 0x70 returns all 32 pad input levels after a two-flop synchronizer. A level on `pad_in` just before rising edge k is visible from rising edge k+1.
- R7: A read of offset 0x78 returns the constant 0x01000C2B.
- R8: Writes to offset 0x70, to offset 0x78 or to any unmapped offset change no state. A read of an unmapped offset returns zero, and `bus_rdata` is zero whenever no read is selected.
- R9: `pad_out[i]` equals bit i of the output-level register at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 for a write access, 0 for a read |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write word: [31:16] enables, [15:0] data |
| bus_rdata | output | 32 | Read data, combinational |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables, 1 = drive |

## Verification
The bench's main target is the enable half of the write word. It uses enable masks that are zero, sparse and full. A design that read enables from the wrong half, or that wrote unenabled bits, would corrupt pins nobody meant to touch. Writes to the high words must leave the low pins intact, and writes to the read-only and unmapped offsets must leave every register unchanged. A decoder that aliases 0x70 or 0x78 onto a writable word would fail there. The bench also times the external-port view against the two-stage delay, so a design with one stage or three would show values one cycle early or late. The read-back upper half must be zero, and echoing the enables there would be flagged.

// File: rtl/gpio_hw_pkg.sv
package gpio_hw_pkg;
  localparam int HALF_W     = 16;
  localparam int WORD_W     = 2 * HALF_W;
  localparam int N_HALVES   = WORD_W / HALF_W;
  localparam int ADDR_W     = 8;
  localparam int HALF_STEP  = 4;
  localparam int SYNC_DEPTH = 2;

  localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_PINS  = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_IDENT = 8'h78;

  localparam logic [WORD_W-1:0] IDENT_CODE = 32'h0100_0C2B;

  function automatic logic [HALF_W-1:0] masked_merge(
    input logic [HALF_W-1:0] old_q,
    input logic [WORD_W-1:0] wword
  );
    logic [HALF_W-1:0] en;
    en = wword[WORD_W-1:HALF_W];
    return (old_q & ~en) | (wword[HALF_W-1:0] & en);
  endfunction
endpackage

// File: rtl/gpio_hw_half_reg.sv
module gpio_hw_half_reg
  import gpio_hw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wword,
  output logic [HALF_W-1:0] q
);
  logic [HALF_W-1:0] q_r;
  logic [HALF_W-1:0] q_next;

  always_comb begin
    q_next = q_r;
    if (wr_en) q_next = masked_merge(q_r, wword);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= '0;
    else if (wr_en) q_r <= q_next;
  end

  assign q = q_r;
endmodule

// File: rtl/gpio_hw_masked_reg.sv
module gpio_hw_masked_reg
  import gpio_hw_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wword,
  output logic [WORD_W-1:0] q
);
  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    localparam logic [ADDR_W-1:0] HOFS = BASE + ADDR_W'(h * HALF_STEP);
    logic hit;
    assign hit = wr && (addr == HOFS);
    gpio_hw_half_reg u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (hit),
      .wword (wword),
      .q     (q[h*HALF_W +: HALF_W])
    );
  end
endmodule

// File: rtl/gpio_hw_sync.sv
module gpio_hw_sync
  import gpio_hw_pkg::*;
#(
  parameter int W      = WORD_W,
  parameter int STAGES = SYNC_DEPTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] src;
    if (s == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stage[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= src;
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_hw_bank.sv
module gpio_hw_bank
  import gpio_hw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [WORD_W-1:0] pad_in,
  output logic [WORD_W-1:0] pad_out,
  output logic [WORD_W-1:0] pad_oe
);
  localparam logic [ADDR_W-1:0] OFS_LEVEL_HI = OFS_LEVEL + ADDR_W'(HALF_STEP);
  localparam logic [ADDR_W-1:0] OFS_DIR_HI   = OFS_DIR + ADDR_W'(HALF_STEP);

  logic              wr_strobe;
  logic              rd_strobe;
  logic [WORD_W-1:0] level_q;
  logic [WORD_W-1:0] dir_q;
  logic [WORD_W-1:0] pins_q;
  logic [WORD_W-1:0] rd_mux;

  assign wr_strobe = bus_sel && bus_wr;
  assign rd_strobe = bus_sel && !bus_wr;

  gpio_hw_masked_reg #(.BASE(OFS_LEVEL)) u_level (
    .clk (clk), .rst_n (rst_n), .wr (wr_strobe),
    .addr (bus_addr), .wword (bus_wdata), .q (level_q)
  );

  gpio_hw_masked_reg #(.BASE(OFS_DIR)) u_dir (
    .clk (clk), .rst_n (rst_n), .wr (wr_strobe),
    .addr (bus_addr), .wword (bus_wdata), .q (dir_q)
  );

  gpio_hw_sync #(.W(WORD_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk), .rst_n (rst_n), .d (pad_in), .q (pins_q)
  );

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      OFS_LEVEL:    rd_mux = {{HALF_W{1'b0}}, level_q[HALF_W-1:0]};
      OFS_LEVEL_HI: rd_mux = {{HALF_W{1'b0}}, level_q[WORD_W-1:HALF_W]};
      OFS_DIR:      rd_mux = {{HALF_W{1'b0}}, dir_q[HALF_W-1:0]};
      OFS_DIR_HI:   rd_mux = {{HALF_W{1'b0}}, dir_q[WORD_W-1:HALF_W]};
      OFS_PINS:     rd_mux = pins_q;
      OFS_IDENT:    rd_mux = IDENT_CODE;
      default:      rd_mux = '0;
    endcase
  end

  assign bus_rdata = rd_strobe ? rd_mux : '0;
  assign pad_out   = level_q;
  assign pad_oe    = dir_q;
endmodule

// File: rtl/gpio_hw_bank_chk.sv
module gpio_hw_bank_chk
  import gpio_hw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [WORD_W-1:0] pad_in,
  input logic [WORD_W-1:0] pad_out,
  input logic [WORD_W-1:0] pad_oe
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_idle_R1: assert (pad_out == '0 && pad_oe == '0);
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(pad_out) && $stable(pad_oe));

  assert_zero_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_wdata[WORD_W-1:HALF_W] == '0)
      |=> $stable(pad_out) && $stable(pad_oe));

  assert_high_spares_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 8'h04) |=> $stable(pad_out[HALF_W-1:0]));

  assert_dir_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 8'h0C) |=> $stable(pad_oe[HALF_W-1:0]) && $stable(pad_out));

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[ADDR_W-1:4] == '0) |-> bus_rdata[WORD_W-1:HALF_W] == '0);

  assert_pins_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && bus_sel && !bus_wr && bus_addr == OFS_PINS)
      |-> bus_rdata == $past(pad_in, 2));

  assert_ident_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == OFS_IDENT) |-> bus_rdata == IDENT_CODE);

  assert_ro_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr >= 8'h10) |=> $stable(pad_out) && $stable(pad_oe));

  assert_no_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |-> bus_rdata == '0);
endmodule

bind gpio_hw_bank gpio_hw_bank_chk u_chk (.*);

// File: tb/gpio_hw_bank_bench.sv
`timescale 1ns/1ps
module gpio_hw_bank_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  gpio_hw_bank u_gpio_hw_bank (
    .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // behavioural reference: plain integers and a two-entry delay queue
  logic [15:0] m_lvl [2];
  logic [15:0] m_dir [2];
  logic [31:0] m_dly [$];

  function automatic logic [15:0] merge(input logic [15:0] o, input logic [31:0] w);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) r[b] = w[b+16] ? w[b] : o[b];
    return r;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (!(bus_sel && !bus_wr)) return 32'h0;
    case (a)
      8'h00: return {16'h0, m_lvl[0]};
      8'h04: return {16'h0, m_lvl[1]};
      8'h08: return {16'h0, m_dir[0]};
      8'h0C: return {16'h0, m_dir[1]};
      8'h70: return m_dly[0];
      8'h78: return 32'h0100_0C2B;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08, 8'h0C: return "R5";
      8'h70: return "R6";
      8'h78: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lvl[0] = '0; m_lvl[1] = '0; m_dir[0] = '0; m_dir[1] = '0;
      m_dly = '{32'h0, 32'h0};
    end else begin
      m_dly.push_back(pad_in);
      void'(m_dly.pop_front());
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          8'h00: m_lvl[0] = merge(m_lvl[0], bus_wdata);
          8'h04: m_lvl[1] = merge(m_lvl[1], bus_wdata);
          8'h08: m_dir[0] = merge(m_dir[0], bus_wdata);
          8'h0C: m_dir[1] = merge(m_dir[1], bus_wdata);
          default: ;
        endcase
      end
    end
    #2;
    if (!done) begin
      chk("R9", pad_out, {m_lvl[1], m_lvl[0]});
      chk("R4", pad_oe,  {m_dir[1], m_dir[0]});
      chk(rd_tag(bus_addr), bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 chk(tag, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  logic [31:0] lfsr;

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pad_in = 0;
    repeat (3) @(negedge clk);
    chk("R1", pad_out, 32'h0);
    chk("R1", pad_oe, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", pad_oe, 32'h0);

    // R2: enables select which data bits land
    wr(8'h00, 32'h00FF_A5A5);
    rd("R2", 8'h00, 32'h0000_00A5);
    wr(8'h00, 32'h0F00_FFFF);
    rd("R2", 8'h00, 32'h0000_0FA5);
    wr(8'h00, 32'h0000_FFFF);
    rd("R2", 8'h00, 32'h0000_0FA5);

    // R3: high word leaves low pins alone
    wr(8'h04, 32'hFFFF_1234);
    chk("R3", pad_out, 32'h1234_0FA5);
    rd("R5", 8'h04, 32'h0000_1234);

    // R4: direction halves
    wr(8'h08, 32'h00FF_00F0);
    chk("R4", pad_oe, 32'h0000_00F0);
    wr(8'h0C, 32'h8000_8000);
    chk("R4", pad_oe, 32'h8000_00F0);

    // R6: synchronized pad view
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    @(negedge clk); @(negedge clk);
    rd("R6", 8'h70, 32'hDEAD_BEEF);

    rd("R7", 8'h78, 32'h0100_0C2B);

    // R8: read-only and unmapped writes change nothing
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    chk("R8", pad_out, 32'h1234_0FA5);
    chk("R8", pad_oe, 32'h8000_00F0);
    rd("R8", 8'h40, 32'h0);
    rd("R7", 8'h78, 32'h0100_0C2B);

    // mixed traffic against the reference model
    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      bus_sel = lfsr[0] | lfsr[5];
      bus_wr  = lfsr[1];
      case (lfsr[4:2])
        3'd0: bus_addr = 8'h00;
        3'd1: bus_addr = 8'h04;
        3'd2: bus_addr = 8'h08;
        3'd3: bus_addr = 8'h0C;
        3'd4: bus_addr = 8'h70;
        3'd5: bus_addr = 8'h78;
        3'd6: bus_addr = 8'h10;
        default: bus_addr = 8'h01;
      endcase
      bus_wdata = {lfsr[15:0], lfsr[31:16]} ^ (lfsr[6] ? 32'hFFFF_0000 : 32'h0);
      if (lfsr[7]) pad_in = ~lfsr ^ 32'h5A5A_0F0F;
    end
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule